// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a programmable interval timer built from a 6-bit prescaler feeding an 8-bit down-counter. A narrow write port sets the prescaler divide ratio, the counter reload value and a control byte; the live counter value is always visible on an output, while the prescaler state is kept private. When the prescaler and the counter both finish their count in the same step, a one-cycle interrupt request pulse is produced.

Counting steps come either from the core clock divided by four or from rising edges of an external input, which is resynchronised with two flops plus an edge flop. The same external input can instead gate the divided clock, or act as a start trigger that either restarts a running count or is ignored while a count is in progress. A count can run once and halt at zero, or reload itself and repeat forever.

Top module: `prescaled_timer`

## Requirements
- R1: The prescaler reload is written at address 0 from data bits [5:0]; values 1 to 63 divide by that value and 0 divides by 64.
- R2: The counter reload is written at address 1 from data bits [7:0]; values 1 to 255 count that many steps and 0 counts 256 steps; `count_out` shows the low 8 bits of the live count (a loaded 256 reads as 0).
- R3: `irq` is a single-cycle pulse raised only when the prescaler and the counter end their count in the same step; in repeat mode with the internal source the pulses are exactly 4*P*N clock cycles apart (P prescale ratio, N count length).
- R4: With control bit 2 clear (single pass), the counter halts at 0 after its interrupt and raises no further interrupt.
- R5: The control byte is written at address 2: bit 0 enables counting, bit 1 reloads prescaler and counter from their reload values; writing bit 0 clear freezes the count, writing bit 0 set with bit 1 clear resumes from the frozen count, and resuming from a count of 0 reloads.
- R6: Control bits [4:3] select the step source: 0 is the clock divided by four (external input ignored), 1 is each synchronised rising edge of `ext_in`.
- R7: Source 2 counts divided-clock steps only while the synchronised `ext_in` is high; while it is low the count holds.
- R8: Source 3 is triggered: enabling arms the timer with the count loaded but still; a synchronised rising edge of `ext_in` reloads and starts the count; a single pass ending disarms it until the next edge.
- R9: In source 3, control bit 5 clear ignores edges while a count runs; bit 5 set lets each edge reload and restart the running count.
- R10: A control write has priority over a count step in the same cycle: that step is dropped and no interrupt is raised for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 prescaler, 1 counter reload, 2 control |
| wr_data | input | CNT_W | Write data |
| ext_in | input | 1 | Asynchronous external timer input |
| count_out | output | CNT_W | Live counter value |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The collision that matters is a control write landing in the same cycle as the count step that would end the count and raise the interrupt. The bench runs a one-step count that ends every fourth cycle and issues a stop write at each of four consecutive cycle offsets, so one of them always meets the final step; in every case the interrupt line must stay low in the cycle after the write and for a while after. A second overlap, a retrigger edge against a running count, is judged by the arrival time of the interrupt relative to the first and second edges.

// File: rtl/pct_pkg.sv
package pct_pkg;

    typedef enum logic [1:0] {
        SRC_DIV4 = 2'd0,
        SRC_EDGE = 2'd1,
        SRC_GATE = 2'd2,
        SRC_TRIG = 2'd3
    } src_mode_e;

    typedef struct packed {
        logic      retrig;
        src_mode_e mode;
        logic      cont;
        logic      en;
    } cfg_t;

    localparam logic [1:0] ADDR_PRE  = 2'd0;
    localparam logic [1:0] ADDR_INIT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int CLK_DIV = 4;

    function automatic cfg_t cfg_from_byte(input logic [7:0] b);
        cfg_t c;
        c.en     = b[0];
        c.cont   = b[2];
        c.mode   = src_mode_e'(b[4:3]);
        c.retrig = b[5];
        return c;
    endfunction

endpackage

// File: rtl/pct_sync.sv
module pct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], pin};
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/pct_tick.sv
module pct_tick
    import pct_pkg::*;
#(
    parameter int DIV = CLK_DIV
) (
    input  logic      clk,
    input  logic      rst,
    input  src_mode_e mode,
    input  logic      pin_level,
    input  logic      pin_rise,
    output logic      tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;
    logic          div_tick;

    always_ff @(posedge clk) begin
        if (rst)                        div_q <= '0;
        else if (div_q == DW'(DIV - 1)) div_q <= '0;
        else                            div_q <= div_q + 1'b1;
    end

    assign div_tick = (div_q == DW'(DIV - 1));

    always_comb begin
        unique case (mode)
            SRC_EDGE: tick = pin_rise;
            SRC_GATE: tick = div_tick & pin_level;
            default:  tick = div_tick;
        endcase
    end

endmodule

// File: rtl/pct_core.sv
module pct_core
    import pct_pkg::*;
#(
    parameter int PRE_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick,
    input  logic             pin_rise,
    output src_mode_e        mode,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam int PW       = PRE_W + 1;
    localparam int CW       = CNT_W + 1;
    localparam int PRE_FULL = 1 << PRE_W;
    localparam int CNT_FULL = 1 << CNT_W;

    logic [PW-1:0] pre_rl_q, pre_q;
    logic [CW-1:0] init_q, cnt_q;
    cfg_t          cfg_q, new_cfg;
    logic          counting_q, irq_q;
    logic          wr_ctrl, wr_load, trig_fire;
    logic [PW-1:0] pre_wval;
    logic [CW-1:0] init_wval;

    assign new_cfg   = cfg_from_byte(wr_data[7:0]);
    assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_load   = wr_data[1];
    assign pre_wval  = (wr_data[PRE_W-1:0] == '0) ? PW'(PRE_FULL) : {1'b0, wr_data[PRE_W-1:0]};
    assign init_wval = (wr_data == '0) ? CW'(CNT_FULL) : {1'b0, wr_data};
    assign trig_fire = cfg_q.en && (cfg_q.mode == SRC_TRIG) && pin_rise
                       && (cfg_q.retrig || !counting_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_rl_q   <= PW'(PRE_FULL);
            pre_q      <= PW'(PRE_FULL);
            init_q     <= CW'(CNT_FULL);
            cnt_q      <= '0;
            cfg_q      <= '0;
            counting_q <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_en && wr_addr == ADDR_PRE)  pre_rl_q <= pre_wval;
            if (wr_en && wr_addr == ADDR_INIT) init_q   <= init_wval;
            if (wr_ctrl) begin
                cfg_q      <= new_cfg;
                counting_q <= new_cfg.en && (new_cfg.mode != SRC_TRIG);
                if (wr_load || cnt_q == '0) begin
                    cnt_q <= init_q;
                    pre_q <= pre_rl_q;
                end
            end else if (trig_fire) begin
                cnt_q      <= init_q;
                pre_q      <= pre_rl_q;
                counting_q <= 1'b1;
            end else if (counting_q && tick) begin
                if (pre_q == PW'(1)) begin
                    pre_q <= pre_rl_q;
                    if (cnt_q == CW'(1)) begin
                        irq_q <= 1'b1;
                        if (cfg_q.cont) begin
                            cnt_q <= init_q;
                        end else begin
                            cnt_q      <= '0;
                            counting_q <= 1'b0;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end else begin
                    pre_q <= pre_q - 1'b1;
                end
            end
        end
    end

    assign mode  = cfg_q.mode;
    assign count = cnt_q[CNT_W-1:0];
    assign irq   = irq_q;

    // R1: prescaler state stays within its divide range
    assert_pre_range_R1: assert property (@(posedge clk) disable iff (rst)
        (pre_q >= PW'(1)) && (pre_q <= PW'(PRE_FULL)));

    // R2: a running count is never at zero and never above full scale
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= CW'(CNT_FULL)) && (!counting_q || cnt_q != '0));

    // R3: interrupt only follows a joint end of prescaler and counter
    assert_irq_cause_R3: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(pre_q) == PW'(1) && $past(cnt_q) == CW'(1) && $past(counting_q)));

    // R3: interrupt is a single-cycle pulse
    assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    // R4: single pass halts at zero after its interrupt
    assert_single_halt_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !cfg_q.cont) |-> (cnt_q == '0 && !counting_q));

    // R10: a control write suppresses an interrupt for that cycle
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        $past(wr_ctrl) |-> !irq_q);

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import pct_pkg::*;
#(
    parameter int PRE_W       = 6,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_in,
    output logic [CNT_W-1:0] count_out,
    output logic             irq
);
    logic      pin_level, pin_rise, tick;
    src_mode_e mode;

    pct_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (ext_in),
        .level (pin_level),
        .rise  (pin_rise)
    );

    pct_tick #(.DIV(CLK_DIV)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .pin_level (pin_level),
        .pin_rise  (pin_rise),
        .tick      (tick)
    );

    pct_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tick     (tick),
        .pin_rise (pin_rise),
        .mode     (mode),
        .count    (count_out),
        .irq      (irq)
    );

    // R7: with the gate low the count does not move
    assert_gate_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == SRC_GATE && !pin_level && !wr_en) |=> $stable(count_out));

endmodule

// File: tb/test_prescaled_timer.sv
`timescale 1ns/1ps
module test_prescaled_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ext_in = 1'b0;
    logic [7:0] count_out;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    int ext_period = 0;
    logic ext_level = 1'b0;

    prescaled_timer i_prescaled_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_in(ext_in), .count_out(count_out), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin : pin_drv
        int phase = 0;
        forever begin
            @(negedge clk);
            if (ext_period != 0) begin
                phase++;
                if (phase >= ext_period / 2) begin
                    ext_in = ~ext_in;
                    phase  = 0;
                end
            end else begin
                ext_in = ext_level;
                phase  = 0;
            end
        end
    end

    typedef struct packed {
        logic [1:0]  mode;
        logic [5:0]  pre;
        logic [7:0]  init;
        logic [15:0] period;
        logic [15:0] expect_dt;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 6'd1, 8'd1, 16'd0,  16'd4},
        '{2'd0, 6'd3, 8'd5, 16'd0,  16'd60},
        '{2'd0, 6'd0, 8'd2, 16'd0,  16'd512},
        '{2'd0, 6'd2, 8'd0, 16'd0,  16'd2048},
        '{2'd1, 6'd1, 8'd3, 16'd8,  16'd24},
        '{2'd1, 6'd2, 8'd2, 16'd10, 16'd40},
        '{2'd2, 6'd2, 8'd3, 16'd0,  16'd24},
        '{2'd0, 6'd2, 8'd2, 16'd6,  16'd16}
    };

    function automatic string vec_tag(vec_t v);
        if (v.pre == 0)         return "R1";
        if (v.init == 0)        return "R2";
        if (v.mode == 2'd1)     return "R6";
        if (v.mode == 2'd2)     return "R7";
        if (v.period != 0)      return "R6";
        return "R3";
    endfunction

    function automatic logic [7:0] ctl(input bit en, input bit load, input bit cont,
                                       input logic [1:0] mode, input bit retrig);
        return {2'b00, retrig, mode, cont, load, en};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act,
                           input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq(output bit ok);
        ok = 0;
        for (int n = 0; n < 30000; n++) begin
            @(negedge clk);
            if (irq) begin ok = 1; break; end
        end
    endtask

    task automatic count_irqs(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (irq) n++;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        finish_run();
    end

    initial begin : main
        bit ok;
        int t1, t0, n, c;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3", "irq after reset", int'(irq), 0);
        chk("R2", "count after reset", int'(count_out), 0);

        // Vector table: repeat-mode interrupt spacing per source and ratio
        for (int v = 0; v < NV; v++) begin
            wr(2'd2, 8'd0);
            ext_period = int'(VECS[v].period);
            ext_level  = (VECS[v].mode == 2'd2);
            wr(2'd0, {2'b00, VECS[v].pre});
            wr(2'd1, VECS[v].init);
            wr(2'd2, ctl(1, 1, 1, VECS[v].mode, 0));
            wait_irq(ok);
            t1 = cyc;
            wait_irq(ok);
            chk(vec_tag(VECS[v]), "irq spacing", ok ? cyc - t1 : -1, int'(VECS[v].expect_dt));
        end
        wr(2'd2, 8'd0);
        ext_period = 0;
        ext_level  = 1'b0;

        // R4: single pass halts at zero
        wr(2'd0, 8'd1);
        wr(2'd1, 8'd3);
        wr(2'd2, ctl(1, 1, 0, 2'd0, 0));
        wait_irq(ok);
        chk("R4", "single pass irq seen", int'(ok), 1);
        @(negedge clk);
        chk("R4", "count halted at zero", int'(count_out), 0);
        count_irqs(100, n);
        chk("R4", "no irq after single pass", n, 0);
        // R5: resume from zero reloads
        wr(2'd2, ctl(1, 0, 0, 2'd0, 0));
        chk("R5", "resume from zero reloads", int'(count_out), 3);
        wr(2'd2, 8'd0);

        // R5: stop, continue, restart
        wr(2'd0, 8'd4);
        wr(2'd1, 8'd200);
        wr(2'd2, ctl(1, 1, 1, 2'd0, 0));
        repeat (200) @(negedge clk);
        wr(2'd2, ctl(0, 0, 1, 2'd0, 0));
        c = int'(count_out);
        repeat (100) @(negedge clk);
        chk("R5", "stopped count holds", int'(count_out), c);
        wr(2'd2, ctl(1, 0, 1, 2'd0, 0));
        repeat (64) @(negedge clk);
        chk_rng("R5", "continue from held count", int'(count_out), c - 5, c - 3);
        wr(2'd2, ctl(1, 1, 1, 2'd0, 0));
        chk("R5", "restart reloads", int'(count_out), 200);
        wr(2'd2, 8'd0);

        // R2: reload of 256 reads 0, then counts down through 255
        wr(2'd0, 8'd1);
        wr(2'd1, 8'd0);
        wr(2'd2, ctl(1, 1, 1, 2'd0, 0));
        chk("R2", "256 reads as zero", int'(count_out), 0);
        repeat (12) @(negedge clk);
        chk_rng("R2", "count after 256 load", int'(count_out), 252, 254);
        wr(2'd2, 8'd0);

        // R7: gate low holds, gate high counts
        ext_level = 1'b0;
        wr(2'd1, 8'd50);
        wr(2'd2, ctl(1, 1, 1, 2'd2, 0));
        repeat (100) @(negedge clk);
        chk("R7", "gate low holds count", int'(count_out), 50);
        ext_level = 1'b1;
        repeat (40) @(negedge clk);
        chk_rng("R7", "gate high counts", int'(count_out), 38, 42);
        wr(2'd2, 8'd0);
        ext_level = 1'b0;
        repeat (4) @(negedge clk);

        // R8 and R9: non-retriggerable trigger
        wr(2'd1, 8'd20);
        wr(2'd2, ctl(1, 1, 0, 2'd3, 0));
        count_irqs(100, n);
        chk("R8", "armed count waits for edge", int'(count_out) + 1000 * n, 20);
        t0 = cyc;
        ext_level = 1'b1; repeat (4) @(negedge clk);
        ext_level = 1'b0; repeat (36) @(negedge clk);
        ext_level = 1'b1; repeat (4) @(negedge clk);
        ext_level = 1'b0;
        wait_irq(ok);
        chk_rng("R9", "non-retrig ignores second edge", cyc - t0, 76, 88);
        @(negedge clk);
        chk("R8", "single pass disarms at zero", int'(count_out), 0);
        wr(2'd2, 8'd0);

        // R9: retriggerable trigger
        wr(2'd2, ctl(1, 1, 0, 2'd3, 1));
        repeat (8) @(negedge clk);
        t0 = cyc;
        ext_level = 1'b1; repeat (4) @(negedge clk);
        ext_level = 1'b0; repeat (36) @(negedge clk);
        ext_level = 1'b1; repeat (4) @(negedge clk);
        ext_level = 1'b0;
        wait_irq(ok);
        chk_rng("R9", "retrig restarts count", cyc - t0, 116, 128);
        wr(2'd2, 8'd0);

        // R10: stop write swept across the end-of-count cycle
        wr(2'd0, 8'd1);
        wr(2'd1, 8'd1);
        for (int k = 0; k < 4; k++) begin
            wr(2'd2, ctl(1, 1, 1, 2'd0, 0));
            repeat (k + 5) @(negedge clk);
            wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd0;
            @(negedge clk);
            wr_en = 1'b0;
            chk("R10", "irq suppressed by write", int'(irq), 0);
            count_irqs(20, n);
            chk("R10", "no irq after stop", n, 0);
        end

        finish_run();
    end

endmodule